// File: doc/BRIEF.md
# Multi-Mode Host Register Access Port

This block sits between an external processor's parallel bus and the internal register space of a peripheral controller. The host has a narrow 5-bit address bus, a 16-bit data bus, a chip select, separate read and write strobes and an address-latch strobe. Every host pin is sampled in the system clock domain. Strobe edges are recovered by a two-stage synchronizer followed by an edge detector, and each detected edge becomes a single internal register read or write.

The internal space holds 256 registers of 16 bits. The host reaches it in one of three ways, picked by a mode input that is captured once after reset. In pin-addressed mode the five address pins name the register. In bus-latched mode the host places the register number on the data lines and the block latches it when the latch strobe falls. In pointer mode the lowest address pin chooses between an 8-bit pointer register and a data window onto the register the pointer names. The first two modes see only the bottom 32 registers. Pointer mode sees all of them.

A plain register file serves as the back end. The read data register drives the data lines only while both chip select and the read strobe are asserted.

Top module: `hostreg_port`

## Requirements
- R1: `data_oe` is 1 only while `cs_n` and `rd_n` are both 0. Whenever `data_oe` is 0, `data_out` is 0.
- R2: In pin-addressed mode (`mode_sel` = 2'b00, and also 2'b11), a write stores `data_in` into the register numbered by `addr`, and a read returns that register.
- R3: In pin-addressed and bus-latched modes, register number n (0 to 31) maps to internal register n, so registers 20h to FFh cannot be reached.
- R4: In bus-latched mode (`mode_sel` = 2'b01), a falling edge of `ale` latches `data_in[4:0]` as the register number. `data_in[15:5]` and the `addr` pins have no effect on which register is selected.
- R5: In bus-latched mode, the latched register number holds across any number of accesses until the next falling edge of `ale`.
- R6: In pointer mode (`mode_sel` = 2'b10), an access with `addr[0]` = 0 targets the pointer. A write loads `data_in[7:0]` into it, and a read returns `{8'h00, pointer}`.
- R7: In pointer mode, an access with `addr[0]` = 1 reads or writes the register the pointer names, anywhere from 00h to FFh.
- R8: The pointer resets to 00h and keeps its value across data-window accesses.
- R9: `mode_sel` is captured on the first clock after reset is released. Later changes have no effect until the next reset.
- R10: A strobe edge seen while `cs_n` is 1 neither writes nor updates the read data.
- R11: A write lands, and new read data appears, on the third rising clock edge after the strobe falls. Each strobe assertion performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Addressing mode, captured once after reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address latch strobe, latched on its falling edge |
| addr | input | 5 | Host address pins |
| data_in | input | 16 | Host data lines toward the block |
| data_out | output | 16 | Read data toward the host, zero when not enabled |
| data_oe | output | 1 | Enable for the data line drivers |

## Verification
A strobe that falls just after a clock edge reaches the second synchronizer stage at the second rising edge. The edge detector fires in the cycle that follows, and the write or read data capture happens at the third rising edge. Every access task therefore holds the strobe and the bus steady for four falling clock edges, and samples the outputs on a falling edge. A dedicated latency check reads back after exactly two and exactly three falling edges and expects the old and the new data respectively. The output enable is combinational from the pins and is checked in the same half cycle its inputs change. Mode capture needs the two-flop reset release plus one more edge, so every reset task waits five cycles before the first access.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int HOST_AW = 5;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 8;

  typedef enum logic [1:0] {
    AM_PINS    = 2'b00,
    AM_LATCHED = 2'b01,
    AM_POINTER = 2'b10,
    AM_SPARE   = 2'b11
  } amode_e;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[b] <= RST_VAL[b];
        stage2_q[b] <= RST_VAL[b];
      end else begin
        stage1_q[b] <= async_in[b];
        stage2_q[b] <= stage1_q[b];
      end
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile #(
  parameter int IW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/hrp_decode.sv
module hrp_decode
  import hrp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          ale_l,
  input  logic          wr_l,
  input  logic          rd_l,
  input  logic          cs_l,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [IW-1:0] rf_widx,
  output logic [DW-1:0] rf_wdata,
  output logic [IW-1:0] rf_ridx,
  output logic [DW-1:0] rd_data
);
  // state registers
  amode_e        mode_q,   mode_n;
  logic          mode_ok_q, mode_ok_n;
  logic [IW-1:0] ptr_q,    ptr_n;
  logic [AW-1:0] mux_q,    mux_n;
  logic [DW-1:0] rdq_q,    rdq_n;
  logic          ale_p_q,  wr_p_q, rd_p_q;

  // decoded strobes
  logic          ale_fall, wr_fire, rd_fire;
  logic          is_ptr_mode, is_mux_mode, ptr_port;
  logic [IW-1:0] acc_idx;
  amode_e        mode_pick;

  always_comb begin
    ale_fall    = ale_p_q & ~ale_l;
    wr_fire     = wr_p_q & ~wr_l & ~cs_l & mode_ok_q;
    rd_fire     = rd_p_q & ~rd_l & ~cs_l & mode_ok_q;
    is_ptr_mode = (mode_q == AM_POINTER);
    is_mux_mode = (mode_q == AM_LATCHED);
    ptr_port    = is_ptr_mode & ~addr[0];
    if (is_ptr_mode) begin
      acc_idx = ptr_q;
    end else if (is_mux_mode) begin
      acc_idx = {{(IW-AW){1'b0}}, mux_q};
    end else begin
      acc_idx = {{(IW-AW){1'b0}}, addr};
    end
  end

  always_comb begin
    if (mode_sel == AM_SPARE) begin
      mode_pick = AM_PINS;
    end else begin
      mode_pick = amode_e'(mode_sel);
    end
  end

  // next-state logic
  always_comb begin
    mode_n    = mode_q;
    mode_ok_n = mode_ok_q;
    ptr_n     = ptr_q;
    mux_n     = mux_q;
    rdq_n     = rdq_q;
    if (!mode_ok_q) begin
      mode_n    = mode_pick;
      mode_ok_n = 1'b1;
    end
    if (ale_fall) begin
      mux_n = din[AW-1:0];
    end
    if (wr_fire && ptr_port) begin
      ptr_n = din[IW-1:0];
    end
    if (rd_fire) begin
      if (ptr_port) begin
        rdq_n = {{(DW-IW){1'b0}}, ptr_q};
      end else begin
        rdq_n = rf_rdata;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= AM_PINS;
      mode_ok_q <= 1'b0;
      ptr_q     <= '0;
      mux_q     <= '0;
      rdq_q     <= '0;
      ale_p_q   <= 1'b0;
      wr_p_q    <= 1'b1;
      rd_p_q    <= 1'b1;
    end else begin
      mode_q    <= mode_n;
      mode_ok_q <= mode_ok_n;
      ptr_q     <= ptr_n;
      mux_q     <= mux_n;
      rdq_q     <= rdq_n;
      ale_p_q   <= ale_l;
      wr_p_q    <= wr_l;
      rd_p_q    <= rd_l;
    end
  end

  assign rf_we    = wr_fire & ~ptr_port;
  assign rf_widx  = acc_idx;
  assign rf_wdata = din;
  assign rf_ridx  = acc_idx;
  assign rd_data  = rdq_q;

  // R9
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok_q |=> (mode_ok_q && $stable(mode_q)));

  // R3
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !is_ptr_mode) |-> (rf_widx < IW'(1 << AW)));

  // R11
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(mux_q));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && ptr_port) |=> $stable(ptr_q));

  // R10
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_l |=> $stable(rdq_q));
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hrp_pkg::*;
#(
  parameter int AW = HOST_AW,
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ale,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe
);
  localparam int NSYNC = 4;

  logic          rst_meta_q, rst_core_q;
  logic [NSYNC-1:0] pins_raw, pins_sync;
  logic          rf_we;
  logic [IW-1:0] rf_widx, rf_ridx;
  logic [DW-1:0] rf_wdata, rf_rdata, rd_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  assign pins_raw = {ale, cs_n, wr_n, rd_n};

  hrp_sync #(.W(NSYNC), .RST_VAL(4'b0111)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_q),
    .async_in (pins_raw),
    .sync_out (pins_sync)
  );

  hrp_decode #(.AW(AW), .DW(DW), .IW(IW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_core_q),
    .mode_sel (mode_sel),
    .addr     (addr),
    .din      (data_in),
    .ale_l    (pins_sync[3]),
    .cs_l     (pins_sync[2]),
    .wr_l     (pins_sync[1]),
    .rd_l     (pins_sync[0]),
    .rf_rdata (rf_rdata),
    .rf_we    (rf_we),
    .rf_widx  (rf_widx),
    .rf_wdata (rf_wdata),
    .rf_ridx  (rf_ridx),
    .rd_data  (rd_data)
  );

  hrp_regfile #(.IW(IW), .DW(DW)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .widx  (rf_widx),
    .wdata (rf_wdata),
    .ridx  (rf_ridx),
    .rdata (rf_rdata)
  );

  assign data_oe  = ~cs_n & ~rd_n;
  assign data_out = data_oe ? rd_data : '0;

  // R1
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_q)
    (cs_n || rd_n) |-> (!data_oe && data_out == '0));
endmodule

// File: tb/sim_hostreg_port.sv
module sim_hostreg_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        cs_n, rd_n, wr_n, ale;
  logic [4:0]  addr;
  logic [15:0] data_in;
  logic [15:0] data_out;
  logic        data_oe;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  hostreg_port u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .ale(ale), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    ale = 1'b0; addr = '0; data_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
  endtask

  task automatic host_write(input logic [4:0] a, input logic [15:0] d, input logic sel);
    addr = a; data_in = d; cs_n = ~sel; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1; cs_n = 1'b1;
    idle(3);
  endtask

  task automatic host_read(input logic [4:0] a, output logic [15:0] d);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    idle(4);
    d = data_out;
    rd_n = 1'b1; cs_n = 1'b1;
    idle(3);
  endtask

  task automatic latch_reg(input logic [15:0] busval);
    data_in = busval; ale = 1'b1;
    idle(3);
    ale = 1'b0;
    idle(4);
    data_in = 16'hDEAD;
  endtask

  task automatic t_reset_state();
    do_reset(2'b00);
    check("R1 reset oe", {15'd0, data_oe}, 16'd0);
    check("R1 reset data", data_out, 16'h0000);
  endtask

  task automatic t_direct();
    logic [15:0] v;
    host_write(5'h03, 16'hA5A5, 1'b1);
    host_write(5'h1F, 16'h1234, 1'b1);
    host_read(5'h03, v); check("R2 read 03", v, 16'hA5A5);
    host_read(5'h1F, v); check("R2 read 1F", v, 16'h1234);
    // R10: write strobe while deselected
    host_write(5'h03, 16'h0BAD, 1'b0);
    host_read(5'h03, v); check("R10 unselected write", v, 16'hA5A5);
    // R1: read strobe without chip select
    addr = 5'h03; rd_n = 1'b0; cs_n = 1'b1;
    idle(4);
    check("R1 oe no cs", {15'd0, data_oe}, 16'd0);
    check("R1 data no cs", data_out, 16'h0000);
    rd_n = 1'b1;
    idle(3);
    // R10: read data register not updated by that unselected read
    addr = 5'h1F; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    check("R1 oe active", {15'd0, data_oe}, 16'd1);
    check("R10 rdata kept", data_out, 16'hA5A5);
    rd_n = 1'b1; cs_n = 1'b1;
    idle(3);
  endtask

  task automatic t_latency();
    // last read returned A5A5 from 03; now read 1F
    addr = 5'h1F; cs_n = 1'b0; rd_n = 1'b0;
    idle(2);
    check("R11 before third edge", data_out, 16'hA5A5);
    idle(1);
    check("R11 at third edge", data_out, 16'h1234);
    rd_n = 1'b1; cs_n = 1'b1;
    idle(3);
    // spare mode code behaves as pin-addressed
    do_reset(2'b11);
    host_write(5'h07, 16'h7777, 1'b1);
    begin
      logic [15:0] v;
      host_read(5'h07, v); check("R2 spare code", v, 16'h7777);
    end
  endtask

  task automatic t_pointer();
    logic [15:0] v;
    do_reset(2'b10);
    host_read(5'h00, v); check("R8 pointer reset", v, 16'h0000);
    host_write(5'h00, 16'hAB25, 1'b1);
    host_read(5'h00, v); check("R6 pointer readback", v, 16'h0025);
    host_write(5'h01, 16'hBEEF, 1'b1);
    host_write(5'h00, 16'h0003, 1'b1);
    host_read(5'h01, v); check("R3 low reg via window", v, 16'hA5A5);
    host_write(5'h00, 16'h00FF, 1'b1);
    host_write(5'h01, 16'hF00D, 1'b1);
    host_read(5'h01, v); check("R7 reg FF", v, 16'hF00D);
    host_read(5'h01, v);
    host_read(5'h00, v); check("R8 pointer holds", v, 16'h00FF);
    mode_sel = 2'b00;
    idle(2);
    host_read(5'h00, v); check("R9 mode ignored", v, 16'h00FF);
  endtask

  task automatic t_latched();
    logic [15:0] v;
    do_reset(2'b01);
    latch_reg(16'hFFE5);
    host_write(5'h03, 16'h5151, 1'b1);
    latch_reg(16'h0003);
    host_read(5'h05, v); check("R4 addr pins ignored", v, 16'hA5A5);
    host_read(5'h00, v); check("R5 latch holds", v, 16'hA5A5);
    latch_reg(16'h0005);
    host_read(5'h1F, v); check("R4 upper bits ignored", v, 16'h5151);
  endtask

  task automatic t_cross();
    logic [15:0] v;
    do_reset(2'b10);
    host_write(5'h00, 16'h0025, 1'b1);
    host_read(5'h01, v); check("R3 reg 25 untouched", v, 16'hBEEF);
    host_write(5'h00, 16'h0005, 1'b1);
    host_read(5'h01, v); check("R7 reg 05", v, 16'h5151);
    do_reset(2'b00);
    host_read(5'h05, v); check("R3 direct 05 not 25", v, 16'h5151);
  endtask

  initial begin
    t_reset_state();
    t_direct();
    t_latency();
    t_pointer();
    t_latched();
    t_cross();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule